// File: doc/BRIEF.md
# MSI Snooping Cache Line Controller

This block keeps the coherence state of a small direct-mapped cache that shares a bus with other caches. Each line is Invalid, Shared (clean and readable) or Modified (the only copy, writable and dirty). The cache is write-back and keeps other copies coherent by invalidating them; it never broadcasts updates. One port takes processor loads and stores. A second port watches the transactions that other caches place on the bus. The block raises its own bus requests for read misses, write misses and write-backs.

A processor request that the line can serve without help completes in the cycle it is presented. Any other request stalls, with `cpu_ready` low, while the block asks for the bus. It holds its command until the bus has been granted and the transfer is finished. A dirty victim is written back before the new line is fetched. Snooped traffic from other caches can downgrade or invalidate lines at any time except while this block owns the bus. The bus carries one transaction at a time, so a snoop never coincides with this block's grant. A snoop that hits a dirty line raises a one-cycle flush pulse, which tells the data path to supply the dirty data.

The bus and snoop commands share one code: 0 = none, 1 = read miss, 2 = write miss, 3 = write-back. An address splits into an index (low `IDX_W` bits) and a tag (the remaining high bits).

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address misses. `bus_req`, `cpu_ready` and `snoop_flush` are low while no request is presented.
- R2: A read to a Shared or Modified line with a matching tag, and a write to a Modified line with a matching tag, raise `cpu_ready` in the same cycle. Neither raises `bus_req`, and neither changes the line.
- R3: A read that misses issues `bus_cmd`=1 at the requested address. When the transfer completes, the line holds the new tag in Shared.
- R4: A write that misses, or a write to a Shared line with a matching tag, issues `bus_cmd`=2 at the requested address. When the transfer completes, the line holds the tag in Modified.
- R5: A miss whose indexed line is Modified with a different tag first issues `bus_cmd`=3 at the victim address (victim tag joined to the index). The line becomes Invalid, and then the miss transaction follows.
- R6: While a transaction is pending, `bus_req` stays high and `bus_cmd` and `bus_addr` stay unchanged until a cycle with both `bus_gnt` and `bus_done` high. `cpu_ready` is low until the cycle in which the final transaction completes, and it is high in that cycle.
- R7: A snooped read miss (code 1) that hits a Modified line pulses `snoop_flush` in the next cycle and leaves the line Shared.
- R8: A snooped write miss (code 2) that hits a Modified line pulses `snoop_flush` and makes the line Invalid. The same snoop on a Shared line makes it Invalid with no flush.
- R9: A snoop whose tag does not match, a snooped write-back (code 3), and a snooped read miss on a Shared line leave the line unchanged and raise no flush.
- R10: A processor request presented in a cycle with `snoop_valid` high is not served in that cycle: `cpu_ready` stays low and no bus request starts on the next edge.
- R11: If a snoop removes the Modified state of a victim whose write-back is waiting for a grant, the write-back is dropped and the block goes directly to the miss transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | Transaction code |
| bus_addr | output | ADDR_W | Transaction address |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Granted transaction finishes this cycle |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 2 | Snooped transaction code |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_flush | output | 1 | Dirty line hit by the previous snoop is flushed |

## Verification
The bench targets these corner cases:
- A write to a Shared line. A design that treated it as a hit would leave stale copies in other caches.
- A dirty victim. A design that skipped the write-back, or issued it at the new address, would lose the modified data.
- A snoop arriving while a write-back waits for grant. A design that failed to drop the write-back would send stale data after the line had already been flushed.
- A processor request presented alongside a snoop. A design that let the hit through would race the snoop's state update.
- Snooped read and write misses against both Shared and Modified lines. These show whether each snoop downgrades or invalidates correctly, and flushes only when the line is dirty.

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_flush
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam logic [1:0] L_I = 2'd0, L_S = 2'd1, L_M = 2'd2;
  localparam logic [1:0] C_NONE = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_WB = 2'd3;
  localparam logic [1:0] F_IDLE = 2'd0, F_WB = 2'd1, F_MISS = 2'd2;

  logic [1:0]        lst  [LINES];
  logic [TAG_W-1:0]  ltag [LINES];
  logic [1:0]        fsm;
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] r_idx = r_addr[IDX_W-1:0];
  wire [TAG_W-1:0] r_tag = r_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snoop_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snoop_addr[ADDR_W-1:IDX_W];

  wire c_match   = (lst[c_idx] != L_I) && (ltag[c_idx] == c_tag);
  wire c_ok      = c_match && (lst[c_idx] == L_M || !cpu_we);
  wire c_dirty   = (lst[c_idx] == L_M) && !c_match;
  wire accept    = (fsm == F_IDLE) && cpu_req && !snoop_valid;
  wire done_xfer = bus_gnt && bus_done;
  wire s_match   = snoop_valid && (lst[s_idx] != L_I) && (ltag[s_idx] == s_tag);
  wire s_rd_m    = s_match && snoop_cmd == C_RD && lst[s_idx] == L_M;
  wire s_wr      = s_match && snoop_cmd == C_WR;

  assign cpu_ready = (accept && c_ok) || (fsm == F_MISS && done_xfer);
  assign bus_req   = fsm != F_IDLE;
  assign bus_cmd   = (fsm == F_WB) ? C_WB : (fsm == F_MISS) ? (r_we ? C_WR : C_RD) : C_NONE;
  assign bus_addr  = (fsm == F_WB) ? {ltag[r_idx], r_idx} : r_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm    <= F_IDLE;
      r_we   <= 1'b0;
      r_addr <= '0;
    end else begin
      case (fsm)
        F_IDLE: if (accept && !c_ok) begin
          fsm    <= c_dirty ? F_WB : F_MISS;
          r_we   <= cpu_we;
          r_addr <= cpu_addr;
        end
        F_WB: if (done_xfer || (!bus_gnt && lst[r_idx] != L_M)) fsm <= F_MISS;
        F_MISS: if (done_xfer) fsm <= F_IDLE;
        default: fsm <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snoop_flush <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        lst[i]  <= L_I;
        ltag[i] <= '0;
      end
    end else begin
      snoop_flush <= s_rd_m || (s_wr && lst[s_idx] == L_M);
      if (s_rd_m) lst[s_idx] <= L_S;
      else if (s_wr) lst[s_idx] <= L_I;
      else if (fsm == F_WB && done_xfer) lst[r_idx] <= L_I;
      else if (fsm == F_MISS && done_xfer) begin
        lst[r_idx]  <= r_we ? L_M : L_S;
        ltag[r_idx] <= r_tag;
      end
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd != C_WB && !done_xfer) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));
  assert_ready_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && bus_req) |-> done_xfer);
  assert_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_IDLE && cpu_ready) |=> !bus_req);
  assert_downgrade_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_rd_m |=> (snoop_flush && lst[$past(s_idx)] == L_S));
  assert_invalidate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_wr |=> (lst[$past(s_idx)] == L_I));
  assert_snoop_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && fsm == F_IDLE) |=> !bus_req);
endmodule

// File: tb/msi_line_ctrl_bench.sv
module msi_line_ctrl_bench;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 2;
  localparam int TAG_W  = ADDR_W - IDX_W;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic cpu_ready, bus_req, snoop_flush;
  logic [1:0] bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic bus_gnt = 0, bus_done = 0, snoop_valid = 0;
  logic [1:0] snoop_cmd = '0;
  logic [ADDR_W-1:0] snoop_addr = '0;

  int checks = 0, failures = 0;
  logic [1:0] mst [4];
  logic [TAG_W-1:0] mtag [4];

  always #5 clk = ~clk;

  msi_line_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_msi_line_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .snoop_valid(snoop_valid),
    .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr), .snoop_flush(snoop_flush));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
    return {TAG_W'(tag), IDX_W'(idx)};
  endfunction

  task automatic serve(input logic [1:0] cmd, input logic [ADDR_W-1:0] addr, input bit last, input string req);
    int k;
    check(bus_req && bus_cmd == cmd, req, {30'd0, bus_cmd}, {30'd0, cmd});
    check(bus_addr == addr, req, 32'(bus_addr), 32'(addr));
    k = $urandom % 4;
    for (int i = 0; i < k; i++) begin
      @(posedge clk); @(negedge clk); #1;
      check(bus_req && bus_cmd == cmd && bus_addr == addr && !cpu_ready, "R6", {30'd0, bus_cmd}, {30'd0, cmd});
    end
    bus_gnt = 1;
    @(posedge clk); @(negedge clk);
    bus_done = 1; #1;
    check(bus_cmd == cmd && cpu_ready == last, "R6", 32'(cpu_ready), 32'(last));
    @(posedge clk); @(negedge clk);
    bus_gnt = 0; bus_done = 0; #1;
  endtask

  task automatic cpu_op(input bit we, input logic [ADDR_W-1:0] addr);
    int idx;
    logic [TAG_W-1:0] tag;
    bit hit, ok;
    idx = int'(addr[IDX_W-1:0]);
    tag = addr[ADDR_W-1:IDX_W];
    hit = mst[idx] != 0 && mtag[idx] == tag;
    ok = hit && (mst[idx] == 2 || !we);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; #1;
    if (ok) begin
      check(cpu_ready && !bus_req, "R2", {31'd0, cpu_ready}, 32'd1);
      @(posedge clk); @(negedge clk);
      cpu_req = 0; #1;
      check(!bus_req, "R2", {31'd0, bus_req}, 32'd0);
    end else begin
      check(!cpu_ready, "R6", {31'd0, cpu_ready}, 32'd0);
      @(posedge clk); @(negedge clk); #1;
      if (mst[idx] == 2) begin
        serve(2'd3, {mtag[idx], IDX_W'(idx)}, 0, "R5");
        mst[idx] = 0;
      end
      serve(we ? 2'd2 : 2'd1, addr, 1, we ? "R4" : "R3");
      mst[idx] = we ? 2'd2 : 2'd1;
      mtag[idx] = tag;
      cpu_req = 0;
    end
  endtask

  task automatic snoop_op(input logic [1:0] cmd, input logic [ADDR_W-1:0] addr);
    int idx;
    bit hit, fl;
    idx = int'(addr[IDX_W-1:0]);
    hit = mst[idx] != 0 && mtag[idx] == addr[ADDR_W-1:IDX_W];
    fl = hit && mst[idx] == 2 && (cmd == 1 || cmd == 2);
    snoop_valid = 1; snoop_cmd = cmd; snoop_addr = addr;
    @(posedge clk); @(negedge clk);
    snoop_valid = 0; #1;
    check(snoop_flush == fl, !hit || cmd == 3 ? "R9" : (cmd == 1 ? "R7" : "R8"), 32'(snoop_flush), 32'(fl));
    if (hit && cmd == 1 && mst[idx] == 2) mst[idx] = 1;
    else if (hit && cmd == 2) mst[idx] = 0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) begin mst[i] = 0; mtag[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    check(!bus_req && !cpu_ready && !snoop_flush, "R1", {31'd0, bus_req}, 32'd0);
    cpu_req = 1; cpu_we = 0; cpu_addr = mk(5, 1); #1;
    check(!cpu_ready, "R1", {31'd0, cpu_ready}, 32'd0);
    cpu_req = 0; #1;

    cpu_op(0, mk(5, 1));
    cpu_op(0, mk(5, 1));
    cpu_op(1, mk(5, 1));
    cpu_op(1, mk(5, 1));
    cpu_op(0, mk(6, 1));
    snoop_op(2'd1, mk(6, 1));
    snoop_op(2'd2, mk(6, 1));
    cpu_op(0, mk(6, 1));

    cpu_op(1, mk(2, 0));
    cpu_req = 1; cpu_we = 0; cpu_addr = mk(3, 0); snoop_valid = 1; snoop_cmd = 2'd3; snoop_addr = mk(9, 3); #1;
    check(!cpu_ready, "R10", {31'd0, cpu_ready}, 32'd0);
    @(posedge clk); @(negedge clk);
    snoop_valid = 0; #1;
    check(!bus_req, "R10", {31'd0, bus_req}, 32'd0);
    @(posedge clk); @(negedge clk); #1;
    check(bus_cmd == 2'd3 && bus_addr == mk(2, 0), "R5", {30'd0, bus_cmd}, 32'd3);
    snoop_valid = 1; snoop_cmd = 2'd1; snoop_addr = mk(2, 0);
    @(posedge clk); @(negedge clk);
    snoop_valid = 0; #1;
    check(snoop_flush, "R7", {31'd0, snoop_flush}, 32'd1);
    @(posedge clk); @(negedge clk); #1;
    serve(2'd1, mk(3, 0), 1, "R11");
    cpu_req = 0;
    mst[0] = 1; mtag[0] = 3;

    for (int n = 0; n < 400; n++) begin
      int r;
      logic [ADDR_W-1:0] a;
      r = $urandom % 10;
      a = mk($urandom % 3, $urandom % 4);
      if (r < 6) cpu_op(r[0], a);
      else snoop_op(2'($urandom % 4), a);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule